// File: doc/BRIEF.md
# Serial Peripheral Interrupt Aggregator

This block gathers fourteen event pulses from a serial peripheral into a single interrupt line. Each event sets a sticky bit in a status register. Software clears a status bit by writing a one to it. A separate enable mask decides which latched events may drive the interrupt line. The line is high whenever any bit is set in both the mask and the status register.

Software never writes the mask directly. One write-one strobe register turns mask bits on, and a second turns them off. Bits written as zero leave the mask untouched, so two drivers can manage their own sources without a read-modify-write sequence. The mask can be read back at its own address. Register reads are combinational from the address. Writes take effect on the clock edge that samples the write.

Top module: `sirq_hub`

## Requirements
- R1: While reset is asserted, and on leaving it, the mask and status registers read zero and `irq_o` is low.
- R2: A write to offset 0x08 sets every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value. The change is visible after the clock edge that samples the write.
- R3: A write to offset 0x0C clears every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R4: The mask reads back at offset 0x10, in bits [13:0]. A write to 0x10 has no effect on the mask or on the status register.
- R5: A pulse on `evt_i[i]` sets status bit i after the sampling edge, whether or not mask bit i is set. The status bit stays set until it is cleared. The status register reads at offset 0x14.
- R6: A write to offset 0x14 clears every status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R7: If an event pulse and a status clear hit the same bit in the same cycle, that status bit remains set.
- R8: `irq_o` is high exactly when some bit is set in both the mask and the status register. It rises or falls after the edge that changes either register.
- R9: Only bits [13:0] are stored. Write data bits [31:14] are ignored, and read data bits [31:14] are zero. The two strobe offsets (0x08, 0x0C) and any unmapped offset read as zero.
- R10: Source i drives status bit i and mask bit i, in this fixed order:
  - bit 0: receive trigger
  - bit 1: receive empty
  - bit 2: receive full
  - bit 3: transmit empty
  - bit 4: transmit full
  - bit 5: receive overrun
  - bit 6: framing error
  - bit 7: parity error
  - bit 8: receive timeout
  - bit 9: modem status change
  - bit 10: transmit trigger
  - bit 11: transmit nearly full
  - bit 12: transmit overflow
  - bit 13: receive break

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| evt_i | input | 14 | One-cycle event pulses, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 14 sources, a 32-bit data path, an 8-bit offset and a two-stage reset synchroniser. With a 32-bit data path, the bench can drive write data with the bits above the source field set. It can therefore check that those bits are discarded and read back as zero. The sources are fourteen separate pins, so each one can be pulsed on its own to check its bit position. Because the event pins and the register port are independent, the bench can land an event and a status clear on the same edge to exercise the collision rule.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  // Number of interrupt sources handled by the block
  localparam int unsigned SRC_COUNT = 14;

  // Register byte offsets
  localparam logic [7:0] OFS_MASK_SET = 8'h08;
  localparam logic [7:0] OFS_MASK_CLR = 8'h0C;
  localparam logic [7:0] OFS_MASK_RD  = 8'h10;
  localparam logic [7:0] OFS_STATUS   = 8'h14;

  // Bit index of each source; this order is decoded by software
  typedef enum int unsigned {
    SRC_RX_TRIG   = 0,
    SRC_RX_EMPTY  = 1,
    SRC_RX_FULL   = 2,
    SRC_TX_EMPTY  = 3,
    SRC_TX_FULL   = 4,
    SRC_RX_OVRUN  = 5,
    SRC_FRAME_ERR = 6,
    SRC_PARITY    = 7,
    SRC_RX_TMO    = 8,
    SRC_MODEM     = 9,
    SRC_TX_TRIG   = 10,
    SRC_TX_NFULL  = 11,
    SRC_TX_OVFL   = 12,
    SRC_RX_BREAK  = 13
  } src_idx_e;

endpackage

// File: rtl/sirq_rst_sync.sv
module sirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  // Next state: shift a one in behind the asynchronous assertion
  always_comb begin
    chain_n = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_n;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/sirq_regdec.sv
module sirq_regdec #(
  parameter int unsigned NSRC   = 14,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSRC-1:0]   mask_q,
  input  logic [NSRC-1:0]   status_q,
  output logic [NSRC-1:0]   set_bits,
  output logic [NSRC-1:0]   clr_bits,
  output logic [NSRC-1:0]   ack_bits,
  output logic [DATA_W-1:0] rdata
);

  import sirq_pkg::*;

  localparam int unsigned HI_W = DATA_W - NSRC;

  logic hit_set;
  logic hit_clr;
  logic hit_mrd;
  logic hit_sts;
  logic [NSRC-1:0] wbits;
  logic unused_wdata_hi;

  assign hit_set = (addr == ADDR_W'(OFS_MASK_SET));
  assign hit_clr = (addr == ADDR_W'(OFS_MASK_CLR));
  assign hit_mrd = (addr == ADDR_W'(OFS_MASK_RD));
  assign hit_sts = (addr == ADDR_W'(OFS_STATUS));

  // Only the source field of the write data is used
  assign wbits           = wdata[NSRC-1:0];
  assign unused_wdata_hi = ^wdata[DATA_W-1:NSRC];

  always_comb begin
    set_bits = (we && hit_set) ? wbits : '0;
    clr_bits = (we && hit_clr) ? wbits : '0;
    ack_bits = (we && hit_sts) ? wbits : '0;
  end

  // Read mux; the strobe offsets and unmapped offsets read zero
  always_comb begin
    rdata = '0;
    if (hit_mrd) begin
      rdata = {{HI_W{1'b0}}, mask_q};
    end else if (hit_sts) begin
      rdata = {{HI_W{1'b0}}, status_q};
    end
  end

endmodule

// File: rtl/sirq_mask.sv
module sirq_mask #(
  parameter int unsigned NSRC = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_bits,
  input  logic [NSRC-1:0] clr_bits,
  output logic [NSRC-1:0] mask_q
);

  logic [NSRC-1:0] mask_n;
  logic            mask_ce;

  // Clear is applied after set, so a clear always takes priority
  always_comb begin
    mask_ce = (|set_bits) | (|clr_bits);
    mask_n  = (mask_q | set_bits) & ~clr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_ce) begin
      mask_q <= mask_n;
    end
  end

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|set_bits) && !(|clr_bits)) |=> ((mask_q & $past(set_bits)) == $past(set_bits)));

  // R3
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_bits) |=> ((mask_q & $past(clr_bits)) == '0));

  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|set_bits) && !(|clr_bits)) |=> $stable(mask_q));

endmodule

// File: rtl/sirq_status.sv
module sirq_status #(
  parameter int unsigned NSRC = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] ack_bits,
  output logic [NSRC-1:0] status_q
);

  // One sticky cell per source
  for (genvar i = 0; i < NSRC; i++) begin : g_cell
    logic cell_n;
    logic cell_ce;

    // An event on the same edge as a clear keeps the bit set
    always_comb begin
      cell_ce = evt[i] | ack_bits[i];
      cell_n  = evt[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        status_q[i] <= 1'b0;
      end else if (cell_ce) begin
        status_q[i] <= cell_n;
      end
    end
  end

  // R5
  evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((status_q & $past(evt)) == $past(evt)));

  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|ack_bits) |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R6
  ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|evt) && (|ack_bits)) |=> ((status_q & $past(ack_bits)) == '0));

endmodule

// File: rtl/sirq_hub.sv
module sirq_hub #(
  parameter int unsigned NSRC     = sirq_pkg::SRC_COUNT,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned RST_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);

  logic            rst_sync_n;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] status_q;
  logic [NSRC-1:0] set_bits;
  logic [NSRC-1:0] clr_bits;
  logic [NSRC-1:0] ack_bits;

  sirq_rst_sync #(.STAGES(RST_SYNC)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sirq_regdec #(.NSRC(NSRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regdec (
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .mask_q   (mask_q),
    .status_q (status_q),
    .set_bits (set_bits),
    .clr_bits (clr_bits),
    .ack_bits (ack_bits),
    .rdata    (reg_rdata)
  );

  sirq_mask #(.NSRC(NSRC)) u_mask (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_bits (set_bits),
    .clr_bits (clr_bits),
    .mask_q   (mask_q)
  );

  sirq_status #(.NSRC(NSRC)) u_status (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .evt      (evt_i),
    .ack_bits (ack_bits),
    .status_q (status_q)
  );

  assign irq_o = |(mask_q & status_q);

  // R8
  irq_nomask_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mask_q == '0) |-> !irq_o);

  // R8
  irq_nostat_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (status_q == '0) |-> !irq_o);

  // R9
  rdata_hi_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_rdata[DATA_W-1:NSRC] == '0);

endmodule

// File: tb/sirq_hub_bench.sv
module sirq_hub_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [13:0] evt;
  logic        we;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int n_total;
  int n_fail;

  sirq_hub u_sirq_hub (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt),
    .reg_we    (we),
    .reg_addr  (addr),
    .reg_wdata (wdata),
    .reg_rdata (rdata),
    .irq_o     (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_total++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // One cycle of stimulus, returns on the following falling edge
  task automatic drive(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [13:0] e);
    @(negedge clk);
    we = w; addr = a; wdata = d; evt = e;
    @(negedge clk);
    we = 1'b0; evt = '0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic clear_all();
    drive(1'b1, 8'h0C, 32'h3FFF, '0);
    drive(1'b1, 8'h14, 32'h3FFF, '0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    drive(1'b1, 8'h08, 32'h0155, '0);
    drive(1'b0, 8'h00, 0, 14'h2AAA);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    rd(8'h10, v); chk("R1 mask in reset", v, 0);
    rd(8'h14, v); chk("R1 status in reset", v, 0);
    chk("R1 irq in reset", {31'b0, irq}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(8'h10, v); chk("R1 mask after reset", v, 0);
    rd(8'h14, v); chk("R1 status after reset", v, 0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    clear_all();
    drive(1'b1, 8'h08, 32'h0081, '0);
    rd(8'h10, v); chk("R2 set bits 0,7", v, 32'h0081);
    drive(1'b1, 8'h08, 32'h2400, '0);
    rd(8'h10, v); chk("R2 zeros keep mask", v, 32'h2481);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    drive(1'b1, 8'h0C, 32'h0401, '0);
    rd(8'h10, v); chk("R3 clear bits 0,10", v, 32'h2080);
    drive(1'b1, 8'h0C, 32'h0000, '0);
    rd(8'h10, v); chk("R3 zero write no change", v, 32'h2080);
  endtask

  task automatic t_mask_ro();
    logic [31:0] v;
    drive(1'b1, 8'h10, 32'h3FFF, '0);
    rd(8'h10, v); chk("R4 write to mask ignored", v, 32'h2080);
    rd(8'h14, v); chk("R4 status untouched", v, 0);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    clear_all();
    drive(1'b0, 8'h00, 0, 14'h0024);
    repeat (3) @(negedge clk);
    rd(8'h14, v); chk("R5 masked events latched and held", v, 32'h0024);
    chk("R8 masked status no irq", {31'b0, irq}, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    drive(1'b1, 8'h14, 32'h0004, '0);
    rd(8'h14, v); chk("R6 clear bit 2 only", v, 32'h0020);
    drive(1'b1, 8'h14, 32'h0020, '0);
    rd(8'h14, v); chk("R6 clear bit 5", v, 0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    drive(1'b0, 8'h00, 0, 14'h0010);
    drive(1'b1, 8'h14, 32'h0018, 14'h0008);
    rd(8'h14, v); chk("R7 event beats clear", v, 32'h0008);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    clear_all();
    drive(1'b1, 8'h08, 32'h0080, '0);
    chk("R8 no status no irq", {31'b0, irq}, 0);
    drive(1'b0, 8'h00, 0, 14'h0080);
    chk("R8 irq rises", {31'b0, irq}, 1);
    drive(1'b1, 8'h0C, 32'h0080, '0);
    chk("R8 disable drops irq", {31'b0, irq}, 0);
    rd(8'h14, v); chk("R8 status kept while disabled", v, 32'h0080);
    drive(1'b1, 8'h08, 32'h0080, '0);
    chk("R8 re-enable raises irq", {31'b0, irq}, 1);
    drive(1'b1, 8'h14, 32'h0080, '0);
    chk("R8 clear drops irq", {31'b0, irq}, 0);
  endtask

  task automatic t_upper();
    logic [31:0] v;
    clear_all();
    drive(1'b1, 8'h08, 32'hFFFF_FFFF, '0);
    rd(8'h10, v); chk("R9 upper bits dropped", v, 32'h3FFF);
    rd(8'h08, v); chk("R9 set offset reads zero", v, 0);
    rd(8'h0C, v); chk("R9 clear offset reads zero", v, 0);
    rd(8'h18, v); chk("R9 unmapped reads zero", v, 0);
    drive(1'b1, 8'h0C, 32'hFFFF_C000, '0);
    rd(8'h10, v); chk("R9 upper-only clear no effect", v, 32'h3FFF);
  endtask

  task automatic t_order();
    logic [31:0] v;
    clear_all();
    drive(1'b0, 8'h00, 0, 14'h2000);
    rd(8'h14, v); chk("R10 break at bit 13", v, 32'h2000);
    drive(1'b1, 8'h14, 32'h2000, 14'h0001);
    rd(8'h14, v); chk("R10 rx trigger at bit 0", v, 32'h0001);
    drive(1'b1, 8'h08, 32'h0001, '0);
    chk("R10 bit 0 source and mask pair", {31'b0, irq}, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_total++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    n_total = 0; n_fail = 0;
    rst_n = 1'b0; evt = '0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_enable();
    t_disable();
    t_mask_ro();
    t_sticky();
    t_w1c();
    t_collide();
    t_irq();
    t_upper();
    t_order();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule